// File: doc/BRIEF.md
# Seventeen-Bit Bidirectional Storage Transceiver

This block passes a 17-bit word between two shared buses, A and B. Each direction has its own storage element. That element can be open and let the word through as it arrives, hold a word, capture a word on a rising edge of a strobe, or ignore the strobe when a strobe enable is off. Each direction has four controls: an active-low drive enable, an open control, a strobe, and an active-low strobe enable. The same controls exist for the B-to-A direction. The word is never inverted.

The model runs on one system clock. The direction strobes are sampled on that clock, and an edge is a change from 0 to 1 between two consecutive samples. Only state changes on the system clock. The transparent data path and the clock path are combinational.

A clock-forwarding path copies the A-to-B strobe to a forwarded-clock output while the A-to-B drive enable is active. It copies that forwarded clock to a returned-clock output while the B-to-A drive enable is active. A disabled clock output is held low.

The two drive enables should not both be active. If they are, the A-to-B direction keeps the B bus and the B-to-A drivers stay off, so no combinational loop forms through the two buses.

Top module: `ubt_xcvr`

## Requirements
- R1: When a direction's drive enable is high (1), that direction's destination bus is not driven by the block, and a value placed on that bus from outside is seen unchanged.
- R2: When a direction's open control is 1 and the direction drives, its destination bus equals its source bus in the same cycle, bit for bit without inversion, whatever the strobe and strobe enable are.
- R3: With open 0 and strobe enable 0, a strobe sampled 0 and then 1 on consecutive clock edges stores the source word present at the second edge. The stored word appears on the destination bus from the following cycle.
- R4: With open 0, a strobe that stays steady, high or low, leaves the stored word unchanged while the source word changes. A falling strobe also leaves it unchanged.
- R5: With open 0 and strobe enable 1, strobe edges are ignored and the stored word is kept.
- R6: While open is 1 and the strobe is 1, the stored word follows the source word at every clock edge. After open returns to 0, the held word is the source word from the last edge at which both were 1. If the strobe was 0 throughout the open window, the earlier stored word is kept.
- R7: The B-to-A direction obeys R2 to R6 with its own four controls and its own storage, independent of the A-to-B direction.
- R8: The forwarded clock equals the A-to-B strobe while the A-to-B drive enable is 0, and is 0 otherwise. The returned clock equals the forwarded clock while the B-to-A drive enable is 0, and is 0 otherwise. With both enables 0, the returned clock follows the A-to-B strobe.
- R9: With both drive enables 0, only the A-to-B direction drives. The A bus shows the external value and the B bus shows the A-to-B output.
- R10: A synchronous active-high reset clears both stored words and both strobe histories at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all storage updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_bus | inout | 17 | Shared A bus; source for A-to-B, destination for B-to-A |
| b_bus | inout | 17 | Shared B bus; source for B-to-A, destination for A-to-B |
| a2b_en_n | input | 1 | A-to-B drive enable, active low; also gates the forwarded clock |
| a2b_open | input | 1 | A-to-B open control (transparent when 1) |
| a2b_stb | input | 1 | A-to-B strobe; sampled on clk, forwarded to clk_fwd |
| a2b_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| b2a_en_n | input | 1 | B-to-A drive enable, active low; also gates the returned clock |
| b2a_open | input | 1 | B-to-A open control (transparent when 1) |
| b2a_stb | input | 1 | B-to-A strobe, sampled on clk |
| b2a_stb_en_n | input | 1 | B-to-A strobe enable, active low |
| clk_fwd | output | 1 | Forwarded copy of a2b_stb, low when disabled |
| clk_ret | output | 1 | Returned copy of clk_fwd, low when disabled |

## Verification
Open-path data and both clock outputs follow their inputs within the same cycle, so they are due at the first sample after the stimulus changes. A word captured or tracked at a rising clock edge is due on the destination bus in the cycle that edge starts. A closed latch or an ignored strobe must show no change in any later cycle. Stimulus changes on the falling clock edge, and every port is compared half a nanosecond before the next rising edge. The comparison is against a behavioural reference that updates its stored words and strobe history only at rising edges. Key corners are also compared against fixed words chosen beforehand, so one cycle of shift in the design shows up as a mismatch.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    // Per-direction storage controls (drive enable is handled at the top).
    typedef struct packed {
        logic open;      // 1: transparent
        logic stb;       // sampled strobe
        logic stb_en_n;  // 0: strobe edges may capture
    } dir_ctl_t;

    // What the storage element does at the next clock edge.
    typedef enum logic [1:0] {
        ACT_PASS    = 2'd0,  // open, strobe low: output follows, store idle
        ACT_TRACK   = 2'd1,  // open, strobe high: store follows input
        ACT_CAPTURE = 2'd2,  // closed, enabled rising strobe
        ACT_KEEP    = 2'd3   // closed, nothing to do
    } store_act_e;

    function automatic store_act_e pick_action(dir_ctl_t c, logic stb_prev);
        if (c.open)
            return c.stb ? ACT_TRACK : ACT_PASS;
        else if (!c.stb_en_n && c.stb && !stb_prev)
            return ACT_CAPTURE;
        else
            return ACT_KEEP;
    endfunction

    // Bus driver grant: A-to-B wins when both enables are asserted.
    function automatic logic [1:0] drive_grant(logic ab_en_n, logic ba_en_n);
        logic ab_on;
        logic ba_on;
        ab_on = !ab_en_n;
        ba_on = !ba_en_n && ab_en_n;
        return {ab_on, ba_on};
    endfunction

endpackage

// File: rtl/ubt_edge.sv
module ubt_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic stb_q
);
    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= stb;
    end
endmodule

// File: rtl/ubt_store.sv
module ubt_store
    import ubt_pkg::*;
#(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  dir_ctl_t         ctl,
    input  logic             stb_q,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    store_act_e       act;
    logic [WIDTH-1:0] held;

    assign act = pick_action(ctl, stb_q);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (act == ACT_TRACK || act == ACT_CAPTURE)
            held <= din;
    end

    assign dout = ctl.open ? din : held;

    AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (rst) (!ctl.open && !ctl.stb_en_n && ctl.stb && !stb_q) |=> (held == $past(din))); // R3
    AST_STEADY_KEEP: assert property (@(posedge clk) disable iff (rst) (!ctl.open && (ctl.stb == stb_q)) |=> $stable(held)); // R4
    AST_INHIBIT_KEEP: assert property (@(posedge clk) disable iff (rst) (!ctl.open && ctl.stb_en_n) |=> $stable(held)); // R5
    AST_OPEN_TRACK: assert property (@(posedge clk) disable iff (rst) (ctl.open && ctl.stb) |=> (held == $past(din))); // R6
endmodule

// File: rtl/ubt_dir.sv
module ubt_dir
    import ubt_pkg::*;
#(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  dir_ctl_t         ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic stb_q;

    ubt_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .stb   (ctl.stb),
        .stb_q (stb_q)
    );

    ubt_store #(.WIDTH(WIDTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .stb_q (stb_q),
        .din   (din),
        .dout  (dout)
    );
endmodule

// File: rtl/ubt_clkpath.sv
module ubt_clkpath (
    input  logic ab_en_n,
    input  logic ba_en_n,
    input  logic ab_stb,
    output logic clk_fwd,
    output logic clk_ret
);
    assign clk_fwd = ab_stb & ~ab_en_n;
    assign clk_ret = clk_fwd & ~ba_en_n;
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int WIDTH = 17
) (
    input  logic             clk,
    input  logic             rst,
    inout  wire  [WIDTH-1:0] a_bus,
    inout  wire  [WIDTH-1:0] b_bus,
    input  logic             a2b_en_n,
    input  logic             a2b_open,
    input  logic             a2b_stb,
    input  logic             a2b_stb_en_n,
    input  logic             b2a_en_n,
    input  logic             b2a_open,
    input  logic             b2a_stb,
    input  logic             b2a_stb_en_n,
    output logic             clk_fwd,
    output logic             clk_ret
);
    localparam logic [WIDTH-1:0] FLOAT = {WIDTH{1'bz}};

    dir_ctl_t         ctl_ab;
    dir_ctl_t         ctl_ba;
    logic [WIDTH-1:0] dout_ab;
    logic [WIDTH-1:0] dout_ba;
    logic [1:0]       grant;

    assign ctl_ab = '{open: a2b_open, stb: a2b_stb, stb_en_n: a2b_stb_en_n};
    assign ctl_ba = '{open: b2a_open, stb: b2a_stb, stb_en_n: b2a_stb_en_n};
    assign grant  = drive_grant(a2b_en_n, b2a_en_n);

    ubt_dir #(.WIDTH(WIDTH)) u_a2b (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_ab),
        .din  (a_bus),
        .dout (dout_ab)
    );

    ubt_dir #(.WIDTH(WIDTH)) u_b2a (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl_ba),
        .din  (b_bus),
        .dout (dout_ba)
    );

    assign b_bus = grant[1] ? dout_ab : FLOAT;
    assign a_bus = grant[0] ? dout_ba : FLOAT;

    ubt_clkpath u_clk (
        .ab_en_n (a2b_en_n),
        .ba_en_n (b2a_en_n),
        .ab_stb  (a2b_stb),
        .clk_fwd (clk_fwd),
        .clk_ret (clk_ret)
    );

    AST_CONFLICT_YIELD: assert property (@(posedge clk) disable iff (rst) (!a2b_en_n && !b2a_en_n) |-> (b_bus == dout_ab)); // R9
    AST_FEEDBACK_RET: assert property (@(posedge clk) disable iff (rst) (!a2b_en_n && !b2a_en_n) |-> (clk_ret == a2b_stb)); // R8
    AST_FWD_QUIET: assert property (@(posedge clk) disable iff (rst) a2b_en_n |-> (!clk_fwd && !clk_ret)); // R8
endmodule

// File: tb/sim_ubt_xcvr.sv
`timescale 1ns/100ps
module sim_ubt_xcvr;
    localparam int W = 17;
    localparam logic [W-1:0] K1 = 17'h1C3A5, K2 = 17'h0B6D1, K3 = 17'h15A3C;
    localparam logic [W-1:0] K4 = 17'h0F0F3, K5 = 17'h1E1E1, K6 = 17'h03C3C;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic a2b_en_n = 1'b1, ab_open = 1'b0, ab_stb = 1'b0, ab_sen_n = 1'b1;
    logic b2a_en_n = 1'b1, ba_open = 1'b0, ba_stb = 1'b0, ba_sen_n = 1'b1;
    logic [W-1:0] a_drv = '0, b_drv = '0;
    wire  [W-1:0] a_bus, b_bus;
    wire          clk_fwd, clk_ret;
    logic         a_tb_on, b_tb_on;
    bit           chk_on = 1'b0;

    assign a_tb_on = b2a_en_n || !a2b_en_n;
    assign b_tb_on = a2b_en_n;
    assign a_bus = a_tb_on ? a_drv : {W{1'bz}};
    assign b_bus = b_tb_on ? b_drv : {W{1'bz}};

    ubt_xcvr #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .a_bus(a_bus), .b_bus(b_bus),
        .a2b_en_n(a2b_en_n), .a2b_open(ab_open), .a2b_stb(ab_stb), .a2b_stb_en_n(ab_sen_n),
        .b2a_en_n(b2a_en_n), .b2a_open(ba_open), .b2a_stb(ba_stb), .b2a_stb_en_n(ba_sen_n),
        .clk_fwd(clk_fwd), .clk_ret(clk_ret)
    );

    // Reference state
    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic         mq_ab = 1'b0, mq_ba = 1'b0;
    int           n_chk = 0, n_fail = 0;
    string        cur_req = "R10";
    logic [W-1:0] keep;

    function automatic logic [W-1:0] pat(input int i);
        return W'(i * 40503 + 4660) ^ W'(i << 7);
    endfunction

    task automatic bus_model(output logic [W-1:0] av, output logic [W-1:0] bv);
        if (!a2b_en_n) begin
            av = a_drv;
            bv = ab_open ? av : m_ab;
        end else if (!b2a_en_n) begin
            bv = b_drv;
            av = ba_open ? bv : m_ba;
        end else begin
            av = a_drv;
            bv = b_drv;
        end
    endtask

    task automatic check_vec(input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        logic [W-1:0] av, bv;
        bus_model(av, bv);
        if (rst) begin
            m_ab = '0; m_ba = '0; mq_ab = 1'b0; mq_ba = 1'b0;
        end else begin
            if (ab_open ? ab_stb : (!ab_sen_n && ab_stb && !mq_ab)) m_ab = av;
            if (ba_open ? ba_stb : (!ba_sen_n && ba_stb && !mq_ba)) m_ba = bv;
            mq_ab = ab_stb;
            mq_ba = ba_stb;
        end
    endtask

    // Called just after a falling edge; samples before the next rising edge.
    task automatic tick_x(input bit on_a, input logic [W-1:0] ea, input bit on_b, input logic [W-1:0] eb);
        logic [W-1:0] av, bv;
        #1.5;
        if (chk_on) begin
            bus_model(av, bv);
            check_vec("a_bus", a_bus, av);
            check_vec("b_bus", b_bus, bv);
            check_vec("clk_fwd", {{(W-1){1'b0}}, clk_fwd}, {{(W-1){1'b0}}, ab_stb & ~a2b_en_n});
            check_vec("clk_ret", {{(W-1){1'b0}}, clk_ret}, {{(W-1){1'b0}}, ab_stb & ~a2b_en_n & ~b2a_en_n});
            if (on_a) check_vec("a_bus fixed", a_bus, ea);
            if (on_b) check_vec("b_bus fixed", b_bus, eb);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic tick();
        tick_x(1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        chk_on = 1'b1;

        // R10: cleared storage after reset, both directions
        cur_req = "R10";
        a2b_en_n = 1'b0; tick_x(0, '0, 1, '0);
        a2b_en_n = 1'b1; b2a_en_n = 1'b0; tick_x(1, '0, 0, '0);

        // R2: transparent A to B regardless of strobe controls
        cur_req = "R2";
        b2a_en_n = 1'b1; a2b_en_n = 1'b0; ab_open = 1'b1;
        for (int i = 0; i < 8; i++) begin
            a_drv = pat(i); ab_stb = i[0]; ab_sen_n = i[1];
            tick_x(0, '0, 1, pat(i));
        end

        // R6: latch closes with strobe high -> holds last open word
        cur_req = "R6";
        ab_stb = 1'b1; a_drv = K1; tick_x(0, '0, 1, K1);
        ab_open = 1'b0; a_drv = pat(30); tick_x(0, '0, 1, K1);

        // R4: steady strobe high, then falling, then steady low
        cur_req = "R4";
        ab_sen_n = 1'b0;
        for (int i = 0; i < 4; i++) begin a_drv = pat(40 + i); tick_x(0, '0, 1, K1); end
        ab_stb = 1'b0;
        for (int i = 0; i < 4; i++) begin a_drv = pat(45 + i); tick_x(0, '0, 1, K1); end

        // R6: open window with strobe low keeps earlier word
        cur_req = "R6";
        ab_open = 1'b1;
        for (int i = 0; i < 3; i++) begin a_drv = pat(50 + i); tick_x(0, '0, 1, pat(50 + i)); end
        ab_open = 1'b0; a_drv = pat(60); tick_x(0, '0, 1, K1);

        // R3: clocked capture, visible the cycle after the edge
        cur_req = "R3";
        a_drv = K2; tick_x(0, '0, 1, K1);
        ab_stb = 1'b1; tick_x(0, '0, 1, K1);
        a_drv = pat(70); tick_x(0, '0, 1, K2);
        for (int i = 0; i < 8; i++) begin
            ab_stb = i[0]; a_drv = pat(80 + i); tick();
        end

        // R5: strobe enable off -> edges ignored
        cur_req = "R5";
        ab_sen_n = 1'b1; keep = m_ab;
        for (int i = 0; i < 8; i++) begin
            ab_stb = ~ab_stb; a_drv = pat(90 + i); tick_x(0, '0, 1, keep);
        end

        // R1: isolation, external value on B seen unchanged
        cur_req = "R1";
        a2b_en_n = 1'b1; keep = m_ab;
        b_drv = ~keep; tick_x(0, '0, 1, ~keep);
        b_drv = ~keep ^ 17'h000F0; tick_x(0, '0, 1, ~keep ^ 17'h000F0);
        b2a_en_n = 1'b1; a_drv = ~m_ba; tick_x(1, ~m_ba, 0, '0);

        // R7: B to A direction with its own controls
        cur_req = "R7";
        b2a_en_n = 1'b0; ba_open = 1'b1; ba_sen_n = 1'b0; ba_stb = 1'b0;
        for (int i = 0; i < 4; i++) begin b_drv = pat(100 + i); tick_x(1, pat(100 + i), 0, '0); end
        ba_stb = 1'b1; b_drv = K3; tick_x(1, K3, 0, '0);
        ba_open = 1'b0; b_drv = pat(110); tick_x(1, K3, 0, '0);
        ba_stb = 1'b0; b_drv = K4; tick_x(1, K3, 0, '0);
        ba_stb = 1'b1; tick_x(1, K3, 0, '0);
        b_drv = pat(111); tick_x(1, K4, 0, '0);
        ba_sen_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ba_stb = ~ba_stb; b_drv = pat(120 + i); tick_x(1, K4, 0, '0);
        end

        // R8: clock forwarding under every enable pair
        cur_req = "R8";
        for (int e = 0; e < 4; e++) begin
            a2b_en_n = e[0]; b2a_en_n = e[1];
            for (int s = 0; s < 2; s++) begin ab_stb = s[0]; tick(); end
        end

        // R9: both enables low -> A-to-B keeps the buses
        cur_req = "R9";
        a2b_en_n = 1'b0; b2a_en_n = 1'b0; ab_open = 1'b1; ab_stb = 1'b0;
        a_drv = K5; tick_x(1, K5, 1, K5);
        ab_open = 1'b0; a_drv = K6; tick_x(1, K6, 0, '0);
        ba_open = 1'b1; tick_x(1, K6, 0, '0);

        // R10: reset in mid-run clears stored words
        cur_req = "R10";
        b2a_en_n = 1'b1; ab_open = 1'b0; ba_open = 1'b0;
        rst = 1'b1; tick();
        rst = 1'b0; tick_x(0, '0, 1, '0);
        a2b_en_n = 1'b1; b2a_en_n = 1'b0; tick_x(1, '0, 0, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule